// File: doc/BRIEF.md
# Remote Access Fault Tracker

This block sits behind the local cache miss path of a multi-device memory system. It inspects the physical address of each missed request and compares it against the local DRAM window, which is given by a base and an inclusive limit. An address outside that window is a far fault. The block emits a one-cycle pulse for it, together with the address, so the request can be sent on to the remote device. It also counts the fault against the address's page in a small table, which is tagged by page number.

A free-running epoch timer opens a migration window once every `EPOCH` cycles. In the cycle the window opens, the whole table is copied to a shadow copy and the live table is emptied. The next fault is therefore counted in the new epoch while the old one is still being reported. The block then walks the shadow copy, one entry per cycle. For each occupied entry it emits a report with the page and its count. A report whose count is at or above a programmable threshold is also flagged as a migration candidate. Faults are counted at all times, but they only lead to decisions in these periodic batches.

Top module: `rmt_fault_tracker`

## Requirements
- R1: A request with `req_valid` high whose `req_addr` is below `dram_base` or above `dram_limit` (limit inclusive) raises `far_pulse` for exactly the cycle after the one it was sampled in, with `fwd_addr` equal to that address. An address inside the window, or any address with `req_valid` low, raises no pulse.
- R2: Requests that land inside the local window leave the page table unchanged and never appear in a report.
- R3: Each far fault increments the count of the entry whose tag equals its page number, `req_addr >> PAGE_SHIFT`.
- R4: A far fault whose page is not in the table takes the lowest-index empty entry, with count 1. If the table is full, it replaces the entry with the lowest count, taking the lowest index on a tie, and sets the count to 1.
- R5: A count that is all-ones stays all-ones on further faults and never wraps.
- R6: `win_open` pulses for one cycle after every `EPOCH` clock edges, counted from reset release, and at no other time.
- R7: After the `win_open` cycle, entry k of the snapshot is reported in the (k+1)-th cycle, for k = 0 to `ENTRIES-1` in index order. `rpt_valid` is high only for occupied entries and carries `rpt_page` and `rpt_count`.
- R8: `cand_valid` is high together with `rpt_valid` exactly when `rpt_count >= threshold`. With threshold 0, every reported entry is a candidate.
- R9: The snapshot holds the faults counted before the window edge. A fault sampled at that edge, or during the report walk, is counted into the emptied table and is reported in the next window.
- R10: While reset is asserted, all outputs are low and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Missed request present |
| req_addr | input | ADDR_W | Physical address of the missed request |
| dram_base | input | ADDR_W | Lowest local DRAM address |
| dram_limit | input | ADDR_W | Highest local DRAM address (inclusive) |
| threshold | input | CNT_W | Candidate threshold |
| far_pulse | output | 1 | Far fault seen; forward the request |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| win_open | output | 1 | Migration window opened this cycle |
| rpt_valid | output | 1 | Report beat valid |
| rpt_page | output | ADDR_W-PAGE_SHIFT | Reported page number |
| rpt_count | output | CNT_W | Reported fault count |
| cand_valid | output | 1 | Reported page is a migration candidate |

## Verification
A wrong table entry stays hidden until the next window. It shows at the ports only during the report walk that follows, up to `EPOCH+ENTRIES` cycles later, as a wrong page, count or candidate flag in a known index slot. The bench therefore runs many windows and checks every report beat against an arithmetic model of allocation, replacement and saturation. A wrong range decision or a wrong epoch count shows one cycle after the request or the window edge, and the bench checks both on every cycle.

// File: rtl/rft_pkg.sv
package rft_pkg;
   typedef enum logic {PH_COLLECT = 1'b0, PH_REPORT = 1'b1} phase_e;
endpackage

// File: rtl/rft_range_check.sv
module rft_range_check #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] dram_base,
   input  logic [ADDR_W-1:0] dram_limit,
   output logic              far_now,
   output logic              far_pulse,
   output logic [ADDR_W-1:0] fwd_addr
);
   assign far_now = req_valid && ((req_addr < dram_base) || (req_addr > dram_limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         far_pulse <= 1'b0;
         fwd_addr  <= '0;
      end else begin
         far_pulse <= far_now;
         if (far_now) fwd_addr <= req_addr;
      end
   end
endmodule

// File: rtl/rft_epoch_timer.sv
module rft_epoch_timer #(
   parameter int EPOCH = 10000
) (
   input  logic clk,
   input  logic rst_n,
   output logic open_now,
   output logic win_open
);
   localparam int CW = $clog2(EPOCH);
   localparam logic [CW-1:0] LAST = CW'(EPOCH - 1);

   logic [CW-1:0] cnt_q;

   assign open_now = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         win_open <= 1'b0;
      end else begin
         cnt_q    <= open_now ? '0 : cnt_q + 1'b1;
         win_open <= open_now;
      end
   end
endmodule

// File: rtl/rft_page_table.sv
module rft_page_table #(
   parameter int ENTRIES = 16,
   parameter int PAGE_W  = 20,
   parameter int CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault,
   input  logic [PAGE_W-1:0] page,
   input  logic              snap,
   output logic              snap_val [ENTRIES],
   output logic [PAGE_W-1:0] snap_tag [ENTRIES],
   output logic [CNT_W-1:0]  snap_cnt [ENTRIES]
);
   localparam int IW = $clog2(ENTRIES);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic              val_q [ENTRIES];
   logic [PAGE_W-1:0] tag_q [ENTRIES];
   logic [CNT_W-1:0]  cnt_q [ENTRIES];

   logic              eff_val [ENTRIES];
   logic [ENTRIES-1:0] hit;
   logic              any_hit, any_free;
   logic [IW-1:0]     hit_idx, free_idx, vic_idx, tgt_idx;
   logic [CNT_W-1:0]  best;

   // a window edge empties the table before the same-cycle fault lands
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign eff_val[i] = val_q[i] && !snap;
      assign hit[i]     = eff_val[i] && (tag_q[i] == page);
   end

   assign any_hit = |hit;

   always_comb begin
      hit_idx  = '0;
      free_idx = '0;
      any_free = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hit[i]) hit_idx = IW'(i);
         if (!eff_val[i]) begin
            free_idx = IW'(i);
            any_free = 1'b1;
         end
      end
   end

   always_comb begin
      vic_idx = '0;
      best    = cnt_q[0];
      for (int i = 1; i < ENTRIES; i++) begin
         if (cnt_q[i] < best) begin
            best    = cnt_q[i];
            vic_idx = IW'(i);
         end
      end
   end

   assign tgt_idx = any_hit ? hit_idx : (any_free ? free_idx : vic_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) begin
            val_q[i]    <= 1'b0;
            tag_q[i]    <= '0;
            cnt_q[i]    <= '0;
            snap_val[i] <= 1'b0;
            snap_tag[i] <= '0;
            snap_cnt[i] <= '0;
         end
      end else begin
         if (snap) begin
            for (int i = 0; i < ENTRIES; i++) begin
               snap_val[i] <= val_q[i];
               snap_tag[i] <= tag_q[i];
               snap_cnt[i] <= cnt_q[i];
               val_q[i]    <= 1'b0;
               cnt_q[i]    <= '0;
            end
         end
         if (fault) begin
            val_q[tgt_idx] <= 1'b1;
            tag_q[tgt_idx] <= page;
            if (any_hit)
               cnt_q[tgt_idx] <= (cnt_q[tgt_idx] == CMAX) ? CMAX : cnt_q[tgt_idx] + 1'b1;
            else
               cnt_q[tgt_idx] <= CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/rft_report_scan.sv
module rft_report_scan
   import rft_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int PAGE_W  = 20,
   parameter int CNT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap,
   input  logic              snap_val [ENTRIES],
   input  logic [PAGE_W-1:0] snap_tag [ENTRIES],
   input  logic [CNT_W-1:0]  snap_cnt [ENTRIES],
   input  logic [CNT_W-1:0]  threshold,
   output logic              rpt_valid,
   output logic [PAGE_W-1:0] rpt_page,
   output logic [CNT_W-1:0]  rpt_count,
   output logic              cand_valid
);
   localparam int IW = $clog2(ENTRIES);
   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

   phase_e        phase_q;
   logic [IW-1:0] idx_q;
   logic          beat;

   assign beat = (phase_q == PH_REPORT) && snap_val[idx_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_COLLECT;
         idx_q      <= '0;
         rpt_valid  <= 1'b0;
         rpt_page   <= '0;
         rpt_count  <= '0;
         cand_valid <= 1'b0;
      end else begin
         rpt_valid  <= beat;
         cand_valid <= beat && (snap_cnt[idx_q] >= threshold);
         if (beat) begin
            rpt_page  <= snap_tag[idx_q];
            rpt_count <= snap_cnt[idx_q];
         end
         if (phase_q == PH_REPORT) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) phase_q <= PH_COLLECT;
         end
         if (snap) begin
            phase_q <= PH_REPORT;
            idx_q   <= '0;
         end
      end
   end
endmodule

// File: rtl/rmt_fault_tracker.sv
module rmt_fault_tracker #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int ENTRIES    = 16,
   parameter int CNT_W      = 8,
   parameter int EPOCH      = 10000
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   input  logic [ADDR_W-1:0]          dram_base,
   input  logic [ADDR_W-1:0]          dram_limit,
   input  logic [CNT_W-1:0]           threshold,
   output logic                       far_pulse,
   output logic [ADDR_W-1:0]          fwd_addr,
   output logic                       win_open,
   output logic                       rpt_valid,
   output logic [ADDR_W-PAGE_SHIFT-1:0] rpt_page,
   output logic [CNT_W-1:0]           rpt_count,
   output logic                       cand_valid
);
   localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("PAGE_SHIFT must lie inside the address width");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (EPOCH <= ENTRIES + 1) begin : g_bad_epoch
      $error("EPOCH must exceed the report walk length");
   end

   logic              far_now, open_now;
   logic              s_val [ENTRIES];
   logic [PAGE_W-1:0] s_tag [ENTRIES];
   logic [CNT_W-1:0]  s_cnt [ENTRIES];

   rft_range_check #(.ADDR_W(ADDR_W)) u_range (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .dram_base(dram_base), .dram_limit(dram_limit),
      .far_now(far_now), .far_pulse(far_pulse), .fwd_addr(fwd_addr)
   );

   rft_epoch_timer #(.EPOCH(EPOCH)) u_timer (
      .clk(clk), .rst_n(rst_n), .open_now(open_now), .win_open(win_open)
   );

   rft_page_table #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_table (
      .clk(clk), .rst_n(rst_n), .fault(far_now),
      .page(req_addr[ADDR_W-1:PAGE_SHIFT]), .snap(open_now),
      .snap_val(s_val), .snap_tag(s_tag), .snap_cnt(s_cnt)
   );

   rft_report_scan #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .snap(open_now),
      .snap_val(s_val), .snap_tag(s_tag), .snap_cnt(s_cnt), .threshold(threshold),
      .rpt_valid(rpt_valid), .rpt_page(rpt_page), .rpt_count(rpt_count),
      .cand_valid(cand_valid)
   );
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 16,
   parameter int CNT_W   = 8,
   parameter int EPOCH   = 10000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic [ADDR_W-1:0] dram_base,
   input logic [ADDR_W-1:0] dram_limit,
   input logic [CNT_W-1:0]  threshold,
   input logic              far_pulse,
   input logic [ADDR_W-1:0] fwd_addr,
   input logic              win_open,
   input logic              rpt_valid,
   input logic [CNT_W-1:0]  rpt_count,
   input logic              cand_valid
);
   localparam int GW = $clog2(EPOCH + 2) + 1;
   localparam logic [GW-1:0] GMAX = GW'(EPOCH + 1);

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gap_q <= '0;
      else if (win_open) gap_q <= GW'(1);
      else if (gap_q != GMAX) gap_q <= gap_q + 1'b1;
   end

   // R1
   far_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      far_pulse |-> ($past(req_valid) && (fwd_addr == $past(req_addr)) &&
                     (($past(req_addr) < $past(dram_base)) || ($past(req_addr) > $past(dram_limit)))));
   // R1
   far_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && ((req_addr < dram_base) || (req_addr > dram_limit))) |=> far_pulse);
   // R6
   win_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_open |-> (gap_q == GW'(EPOCH)));
   // R6
   win_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= GW'(EPOCH));
   // R7
   rpt_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> ((gap_q >= GW'(1)) && (gap_q <= GW'(ENTRIES))));
   // R5
   rpt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> (rpt_count != '0));
   // R8
   cand_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (rpt_valid && (rpt_count >= $past(threshold))));
endmodule

bind rmt_fault_tracker rft_checker #(
   .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W), .EPOCH(EPOCH)
) u_rft_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
   .dram_base(dram_base), .dram_limit(dram_limit), .threshold(threshold),
   .far_pulse(far_pulse), .fwd_addr(fwd_addr), .win_open(win_open),
   .rpt_valid(rpt_valid), .rpt_count(rpt_count), .cand_valid(cand_valid)
);

// File: tb/rmt_fault_tracker_bench.sv
`timescale 1ns/1ps
module rmt_fault_tracker_bench;
   localparam int AW = 16, PS = 8, NE = 4, CW = 3, EP = 40;
   localparam int PW = AW - PS;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0, dram_base = 16'h1000, dram_limit = 16'h3FFF;
   logic [CW-1:0] threshold = 3'd2;
   logic far_pulse, win_open, rpt_valid, cand_valid;
   logic [AW-1:0] fwd_addr;
   logic [PW-1:0] rpt_page;
   logic [CW-1:0] rpt_count;

   always #10 clk = ~clk;

   rmt_fault_tracker #(.ADDR_W(AW), .PAGE_SHIFT(PS), .ENTRIES(NE), .CNT_W(CW), .EPOCH(EP))
   u_rmt_fault_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .dram_base(dram_base), .dram_limit(dram_limit), .threshold(threshold),
      .far_pulse(far_pulse), .fwd_addr(fwd_addr), .win_open(win_open),
      .rpt_valid(rpt_valid), .rpt_page(rpt_page), .rpt_count(rpt_count),
      .cand_valid(cand_valid)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   string ph = "R3";

   // reference model
   logic          m_val [NE];
   logic [PW-1:0] m_tag [NE];
   logic [CW-1:0] m_cnt [NE];
   logic          s_val [NE];
   logic [PW-1:0] s_tag [NE];
   logic [CW-1:0] s_cnt [NE];
   int ec = 0, sidx = 0;
   bit scanning = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_fault(input logic [PW-1:0] pg);
      int t = -1;
      for (int i = NE - 1; i >= 0; i--) if (m_val[i] && m_tag[i] == pg) t = i;
      if (t >= 0) begin
         if (m_cnt[t] != CMAX) m_cnt[t] = m_cnt[t] + 1'b1;
      end else begin
         for (int i = NE - 1; i >= 0; i--) if (!m_val[i]) t = i;
         if (t < 0) begin
            t = 0;
            for (int i = 1; i < NE; i++) if (m_cnt[i] < m_cnt[t]) t = i;
         end
         m_val[t] = 1'b1; m_tag[t] = pg; m_cnt[t] = 3'd1;
      end
   endtask

   task automatic step(input logic v, input logic [AW-1:0] a);
      logic e_far, e_win, e_rv, e_cd;
      logic [PW-1:0] e_pg;
      logic [CW-1:0] e_ct;
      req_valid = v; req_addr = a;
      e_far = v && ((a < dram_base) || (a > dram_limit));
      e_win = (ec == EP - 1);
      e_rv = scanning && s_val[sidx];
      e_pg = s_tag[sidx]; e_ct = s_cnt[sidx];
      e_cd = e_rv && (e_ct >= threshold);
      if (scanning) begin
         if (sidx == NE - 1) scanning = 0; else sidx++;
      end
      if (e_win) begin
         for (int i = 0; i < NE; i++) begin
            s_val[i] = m_val[i]; s_tag[i] = m_tag[i]; s_cnt[i] = m_cnt[i];
            m_val[i] = 1'b0; m_cnt[i] = '0;
         end
         scanning = 1; sidx = 0;
      end
      ec = e_win ? 0 : ec + 1;
      if (e_far) model_fault(a[AW-1:PS]);
      @(posedge clk);
      @(negedge clk);
      chk("R1 far_pulse", 16'(far_pulse), 16'(e_far));
      if (e_far) chk("R1 fwd_addr", fwd_addr, a);
      chk("R6 win_open", 16'(win_open), 16'(e_win));
      chk({"R7 rpt_valid (", ph, ")"}, 16'(rpt_valid), 16'(e_rv));
      if (e_rv) begin
         chk("R4 rpt_page", 16'(rpt_page), 16'(e_pg));
         chk({ph, " rpt_count"}, 16'(rpt_count), 16'(e_ct));
      end
      chk("R8 cand_valid", 16'(cand_valid), 16'(e_cd));
   endtask

   task automatic to_epoch_start();
      while (ec != 0) step(1'b0, 16'h0);
   endtask

   task automatic next_lfsr();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      for (int i = 0; i < NE; i++) begin
         m_val[i] = 0; m_tag[i] = '0; m_cnt[i] = '0;
         s_val[i] = 0; s_tag[i] = '0; s_cnt[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 far_pulse", 16'(far_pulse), 16'h0);
      chk("R10 win_open", 16'(win_open), 16'h0);
      chk("R10 rpt_valid", 16'(rpt_valid), 16'h0);
      chk("R10 cand_valid", 16'(cand_valid), 16'h0);
      chk("R10 rpt_count", 16'(rpt_count), 16'h0);
      rst_n = 1'b1;

      // R1/R2: boundary sweep around the local window; local hits must not be counted
      ph = "R2";
      step(1, 16'h0FFF); step(1, 16'h1000); step(1, 16'h3FFF); step(1, 16'h4000);
      step(1, 16'h0000); step(1, 16'hFFFF); step(1, 16'h2345); step(0, 16'h5000);
      step(1, 16'h1001); step(1, 16'h3F00); step(1, 16'h40FF); step(0, 16'h0);
      to_epoch_start();

      // R3/R4: scattered faults over six remote pages, four entries -> replacement
      ph = "R3";
      for (int e = 0; e < 4; e++) begin
         threshold = 3'(e);
         for (int c = 0; c < EP; c++) begin
            next_lfsr();
            if (lfsr[0] | lfsr[1])
               step(1, {8'h40 + 8'(lfsr[7:4] % 6), lfsr[15:8]});
            else
               step(1, {4'h2, lfsr[11:0]});
         end
      end
      to_epoch_start();

      // R5: saturation by hammering one page
      ph = "R5";
      threshold = 3'd7;
      for (int c = 0; c < 12; c++) step(1, 16'h5010);
      step(1, 16'h6000); step(1, 16'h6001);
      to_epoch_start();

      // R9: faults every cycle across window edges and report walks
      ph = "R9";
      threshold = 3'd3;
      for (int c = 0; c < 2 * EP + 5; c++) step(1, {8'h70 + 8'(c % 3), 8'(c)});
      to_epoch_start();

      // R8: threshold sweep against counts 1,3,5,7
      ph = "R8";
      for (int t = 0; t < 8; t++) begin
         threshold = 3'(t);
         for (int p = 0; p < 4; p++)
            for (int k = 0; k < 2 * p + 1; k++) step(1, {8'h90 + 8'(p), 8'h00});
         to_epoch_start();
      end
      repeat (NE + 2) step(1'b0, 16'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule